// File: doc/BRIEF.md
# Register Rename Table with Free List

This block renames architectural destination registers to physical registers for one register class of an out-of-order core. It keeps one mapping entry per architectural register and an internal FIFO of free physical registers. A rename request names a destination. The block returns the freshly allocated physical register together with the mapping it displaced, so that later logic can free the displaced register when the renaming instruction retires.

Two combinational lookup ports read the current mapping for source operands. A release port hands retired physical registers back to the free pool. A per-instance parameter names an architectural zero register. That register is never renamed: a rename of it allocates nothing and reports its fixed mapping as both the new and the old register. Setting the parameter to all ones disables this behaviour for classes that have no zero register.

Top module: `rename_table`

## Requirements
- R1: After reset, architectural register i maps to physical register i. The free list holds physical registers N_ARCH to N_PHYS-1 and hands them out in ascending order. Free count is N_PHYS-N_ARCH.
- R2: An accepted rename of a non-zero destination reports the destination's mapping from before the rename as `ren_old`, in the same cycle.
- R3: An accepted rename of a non-zero destination reports the head of the free list as `ren_new` and writes it into the table from the next cycle on. The free list is first-in first-out.
- R4: A rename of the zero register (index ZERO_IDX) allocates nothing and leaves the table unchanged. It reports the zero register's current mapping on both `ren_new` and `ren_old`, and is always ready.
- R5: With ZERO_IDX all ones, every architectural index, including 0, is renamed normally.
- R6: When the free list is empty, `ren_ready` is low for non-zero destinations. An attempted rename then changes neither the table nor the free list.
- R7: The lookup ports `lk_a_phys`/`lk_b_phys` show the mapping as it was before any rename accepted in the same cycle.
- R8: A release with `rel_valid` high appends `rel_phys` to the tail of the free list. A release of physical register 0 is ignored while a zero register is enabled.
- R9: A register released while the free list is empty cannot be allocated in that same cycle. It becomes available on the next cycle.
- R10: The zero register's table entry always holds physical register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ren_valid | input | 1 | Rename request |
| ren_arch | input | AW | Destination architectural register |
| ren_ready | output | 1 | Rename can be accepted this cycle |
| ren_new | output | PW | Newly assigned physical register |
| ren_old | output | PW | Displaced physical register |
| lk_a_arch | input | AW | Source lookup A index |
| lk_a_phys | output | PW | Source lookup A mapping |
| lk_b_arch | input | AW | Source lookup B index |
| lk_b_phys | output | PW | Source lookup B mapping |
| rel_valid | input | 1 | Release request |
| rel_phys | input | PW | Physical register being returned |
| free_count | output | PW+1 | Registers currently free |

## Verification
A corrupt table entry shows up on the lookup ports at once, and on `ren_old` at the next rename of that register. A lost or duplicated free-list slot shows up as a `ren_new` that is out of the expected FIFO order, or as a `free_count` that drifts from the arithmetic model within one cycle. Because of this, the bench sweeps every architectural index through lookups and renames. It also drains the free list to empty and refills it, and it compares each allocation against a reference queue kept in the bench.

// File: rtl/rename_pkg.sv
// Package: shared helpers for the rename table.
// Assumes: widths are derived by callers from counts via clog2.
package rename_pkg;
    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_ZERO   = 2'd1,
        OP_ALLOC  = 2'd2,
        OP_STALL  = 2'd3
    } ren_op_e;
endpackage

// File: rtl/rename_freelist.sv
// Module: rename_freelist
// Circular FIFO of free physical register numbers.
// Assumes: push never exceeds capacity (each phys reg freed once).
// A pop reads the head only if the list was non-empty at cycle start,
// so a same-cycle push to an empty list is not visible until next cycle.
module rename_freelist #(
    parameter int N_ARCH = 8,
    parameter int N_PHYS = 16,
    localparam int PW    = $clog2(N_PHYS),
    localparam int DEPTH = N_PHYS,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic          push,
    input  logic [PW-1:0] push_val,
    output logic [PW-1:0] head_val,
    output logic          not_empty,
    output logic [PW:0]   count
);
    logic [PW-1:0] slots [DEPTH];
    logic [IW-1:0] rd_ptr, wr_ptr;

    assign not_empty = (count != '0);
    assign head_val  = slots[rd_ptr];

    // Reset loads the non-architectural registers in ascending order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                slots[i] <= (i < N_PHYS - N_ARCH) ? PW'(i + N_ARCH) : '0;
        end else if (push) begin
            slots[wr_ptr] <= push_val;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= IW'((N_PHYS - N_ARCH) % DEPTH);
            count  <= (PW+1)'(N_PHYS - N_ARCH);
        end else begin
            if (pop)  rd_ptr <= (rd_ptr == IW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            if (push) wr_ptr <= (wr_ptr == IW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            count <= count + (PW+1)'(push) - (PW+1)'(pop);
        end
    end

    // R6: never pop from an empty list
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> not_empty);
    // R8: occupancy never exceeds capacity
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= (PW+1)'(DEPTH));
    // R9: push into empty list leaves exactly one entry next cycle
    a_r9_push_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (!not_empty && push) |=> (count == (PW+1)'(1)));
endmodule

// File: rtl/rename_maptab.sv
// Module: rename_maptab
// Architectural-to-physical mapping array with one write and three reads.
// Assumes: writes are issued only for non-zero destinations.
module rename_maptab #(
    parameter int N_ARCH = 8,
    parameter int N_PHYS = 16,
    localparam int AW = $clog2(N_ARCH),
    localparam int PW = $clog2(N_PHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_arch,
    input  logic [PW-1:0] wr_phys,
    input  logic [AW-1:0] rd0_arch,
    output logic [PW-1:0] rd0_phys,
    input  logic [AW-1:0] rd1_arch,
    output logic [PW-1:0] rd1_phys,
    input  logic [AW-1:0] rd2_arch,
    output logic [PW-1:0] rd2_phys
);
    logic [PW-1:0] ent [N_ARCH];

    // One register per entry; identity mapping at reset.
    for (genvar g = 0; g < N_ARCH; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent[g] <= PW'(g);
            else if (wr_en && wr_arch == AW'(g))
                ent[g] <= wr_phys;
        end
    end

    assign rd0_phys = ent[rd0_arch];
    assign rd1_phys = ent[rd1_arch];
    assign rd2_phys = ent[rd2_arch];
endmodule

// File: rtl/rename_table.sv
// Module: rename_table
// Rename table for one register class with a built-in free list.
// Assumes: each physical register is released at most once while mapped-out.
// ZERO_IDX all ones disables zero-register handling.
module rename_table
    import rename_pkg::*;
#(
    parameter int N_ARCH   = 8,
    parameter int N_PHYS   = 16,
    parameter int ZERO_IDX = 0,
    localparam int AW = $clog2(N_ARCH),
    localparam int PW = $clog2(N_PHYS),
    localparam bit HAS_ZERO = (ZERO_IDX >= 0) && (ZERO_IDX < N_ARCH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ren_valid,
    input  logic [AW-1:0] ren_arch,
    output logic          ren_ready,
    output logic [PW-1:0] ren_new,
    output logic [PW-1:0] ren_old,
    input  logic [AW-1:0] lk_a_arch,
    output logic [PW-1:0] lk_a_phys,
    input  logic [AW-1:0] lk_b_arch,
    output logic [PW-1:0] lk_b_phys,
    input  logic          rel_valid,
    input  logic [PW-1:0] rel_phys,
    output logic [PW:0]   free_count
);
    logic          is_zero;
    logic          fl_nonempty;
    logic [PW-1:0] fl_head;
    logic [PW-1:0] cur_map;
    logic          do_alloc;
    logic          do_push;
    ren_op_e       op;

    // Decode whether the destination is the protected zero register.
    always_comb begin
        if (HAS_ZERO) is_zero = (ren_arch == AW'(ZERO_IDX));
        else          is_zero = 1'b0;
    end

    // Classify the request for this cycle.
    always_comb begin
        if (!ren_valid)      op = OP_IDLE;
        else if (is_zero)    op = OP_ZERO;
        else if (fl_nonempty) op = OP_ALLOC;
        else                 op = OP_STALL;
    end

    assign do_alloc  = (op == OP_ALLOC);
    assign ren_ready = is_zero || fl_nonempty;
    assign do_push   = rel_valid && !(HAS_ZERO && rel_phys == '0);

    // Result pair: zero register echoes its mapping on both outputs.
    always_comb begin
        ren_old = cur_map;
        ren_new = is_zero ? cur_map : fl_head;
    end

    rename_freelist #(.N_ARCH(N_ARCH), .N_PHYS(N_PHYS)) u_free (
        .clk       (clk),
        .rst_n     (rst_n),
        .pop       (do_alloc),
        .push      (do_push),
        .push_val  (rel_phys),
        .head_val  (fl_head),
        .not_empty (fl_nonempty),
        .count     (free_count)
    );

    rename_maptab #(.N_ARCH(N_ARCH), .N_PHYS(N_PHYS)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (do_alloc),
        .wr_arch  (ren_arch),
        .wr_phys  (fl_head),
        .rd0_arch (ren_arch),
        .rd0_phys (cur_map),
        .rd1_arch (lk_a_arch),
        .rd1_phys (lk_a_phys),
        .rd2_arch (lk_b_arch),
        .rd2_phys (lk_b_phys)
    );

    // R10: zero register entry always maps to physical 0
    generate if (HAS_ZERO) begin : g_zchk
        a_r10_zero_fixed: assert property (@(posedge clk) disable iff (!rst_n)
            (lk_a_arch == AW'(ZERO_IDX)) |-> (lk_a_phys == '0));
        // R4: zero rename leaves free count unchanged when nothing is released
        a_r4_zero_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
            (ren_valid && is_zero && !rel_valid) |=> $stable(free_count));
    end endgenerate
    // R3: accepted allocation consumes one entry when nothing is released
    a_r3_alloc_pops: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && ren_ready && !is_zero && !rel_valid)
        |=> (free_count == $past(free_count) - 1'b1));
    // R6: stalled rename leaves the free count untouched
    a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && !ren_ready && !rel_valid) |=> $stable(free_count));
endmodule

// File: tb/tb_rename_table.sv
module tb_rename_table;
    localparam int NA = 8, NP = 16, AW = 3, PW = 4;
    logic clk = 0, rst_n = 0;
    always #2.5 clk = ~clk;

    logic ren_valid = 0, rel_valid = 0;
    logic [AW-1:0] ren_arch = 0, lk_a_arch = 0, lk_b_arch = 0;
    logic [PW-1:0] rel_phys = 0;
    logic ren_ready;
    logic [PW-1:0] ren_new, ren_old, lk_a_phys, lk_b_phys;
    logic [PW:0] free_count;

    logic ren_valid2 = 0, rel_valid2 = 0;
    logic [AW-1:0] ren_arch2 = 0, lk2 = 0;
    logic [PW-1:0] rel_phys2 = 0;
    logic ren_ready2;
    logic [PW-1:0] ren_new2, ren_old2, lk2_phys, lk2b_phys;
    logic [PW:0] free_count2;

    rename_table #(.N_ARCH(NA), .N_PHYS(NP), .ZERO_IDX(0)) dut (
        .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_arch(ren_arch),
        .ren_ready(ren_ready), .ren_new(ren_new), .ren_old(ren_old),
        .lk_a_arch(lk_a_arch), .lk_a_phys(lk_a_phys),
        .lk_b_arch(lk_b_arch), .lk_b_phys(lk_b_phys),
        .rel_valid(rel_valid), .rel_phys(rel_phys), .free_count(free_count));

    rename_table #(.N_ARCH(NA), .N_PHYS(NP), .ZERO_IDX(-1)) dut_nz (
        .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid2), .ren_arch(ren_arch2),
        .ren_ready(ren_ready2), .ren_new(ren_new2), .ren_old(ren_old2),
        .lk_a_arch(lk2), .lk_a_phys(lk2_phys),
        .lk_b_arch(lk2), .lk_b_phys(lk2b_phys),
        .rel_valid(rel_valid2), .rel_phys(rel_phys2), .free_count(free_count2));

    int checks = 0, errors = 0;
    int model_map [NA];
    int fq [$];

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    // Drive one rename on dut and check it against the model.
    task automatic do_ren(int a, string req);
        ren_valid = 1; ren_arch = AW'(a); #0.5;
        if (a == 0) begin
            chk("R4 new", ren_new, 0); chk("R4 old", ren_old, 0);
            chk("R4 ready", ren_ready, 1);
        end else if (fq.size() == 0) begin
            chk("R6 ready", ren_ready, 0);
        end else begin
            chk({req, " R2 old"}, ren_old, model_map[a]);
            chk({req, " R3 new"}, ren_new, fq[0]);
            model_map[a] = fq.pop_front();
        end
        tick(); ren_valid = 0;
    endtask

    task automatic do_rel(int p);
        rel_valid = 1; rel_phys = PW'(p);
        if (p != 0) fq.push_back(p);
        tick(); rel_valid = 0;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1; #1;
        for (int i = 0; i < NA; i++) model_map[i] = i;
        for (int i = NA; i < NP; i++) fq.push_back(i);
        // R1: reset mapping via lookups, free count
        for (int i = 0; i < NA; i++) begin
            lk_a_arch = AW'(i); lk_b_arch = AW'(NA-1-i); #0.5;
            chk("R1 lkA", lk_a_phys, i); chk("R1 lkB", lk_b_phys, NA-1-i);
        end
        chk("R1 count", free_count, NP-NA);
        // R4: zero register rename changes nothing
        do_ren(0, "R4");
        chk("R4 count", free_count, NP-NA);
        lk_a_arch = 0; #0.5; chk("R10 zero map", lk_a_phys, 0);
        // R7: lookup shows pre-rename value in same cycle
        lk_a_arch = 3; ren_valid = 1; ren_arch = 3; #0.5;
        chk("R7 lookup before", lk_a_phys, model_map[3]);
        ren_valid = 0;
        do_ren(3, "R3");
        lk_a_arch = 3; #0.5; chk("R3 table written", lk_a_phys, model_map[3]);
        // sweep renames over all arch regs until list empty
        for (int k = 0; fq.size() > 0; k++) do_ren(1 + (k % (NA-1)), "sweep");
        chk("R6 count empty", free_count, 0);
        // R6: stalled rename leaves state unchanged
        do_ren(5, "R6");
        lk_a_arch = 5; #0.5; chk("R6 map kept", lk_a_phys, model_map[5]);
        chk("R6 count kept", free_count, 0);
        // R8: release of phys 0 ignored
        do_rel(0);
        chk("R8 zero release ignored", free_count, 0);
        // R9: release and rename same cycle with empty list
        rel_valid = 1; rel_phys = 9; ren_valid = 1; ren_arch = 2; #0.5;
        chk("R9 not ready", ren_ready, 0);
        tick(); rel_valid = 0; ren_valid = 0;
        fq.push_back(9);
        chk("R9 count", free_count, 1);
        lk_a_arch = 2; #0.5; chk("R9 map unchanged", lk_a_phys, model_map[2]);
        do_ren(2, "R9 next");
        // R8: FIFO order of releases
        do_rel(12); do_rel(4); do_rel(7);
        chk("R8 count", free_count, 3);
        do_ren(6, "R8"); do_ren(1, "R8"); do_ren(7, "R8");
        // final sweep of table
        for (int i = 0; i < NA; i++) begin
            lk_b_arch = AW'(i); #0.5; chk("R2 final map", lk_b_phys, model_map[i]);
        end
        // R5: no-zero instance renames arch 0
        ren_valid2 = 1; ren_arch2 = 0; #0.5;
        chk("R5 ready", ren_ready2, 1);
        chk("R5 new", ren_new2, NA); chk("R5 old", ren_old2, 0);
        tick(); ren_valid2 = 0; lk2 = 0; #0.5;
        chk("R5 map", lk2_phys, NA);
        chk("R5 count", free_count2, NP-NA-1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule